// File: doc/BRIEF.md
# Interrupt Pending, Enable and Delegation Register File

This block holds the three machine-level interrupt control registers of a processor hart: the pending word, the enable word and the delegation word. It also provides the supervisor-level pending and enable views. A single CSR port reaches these registers. It has a write strobe, a select code that picks one of five register views, write data, and combinational read data for the selected view. The supervisor views act as windows through the delegation word. A supervisor read returns only the bits that are delegated, and a supervisor write changes only those bits.

Some pending bits belong to hardware. Four request lines (machine software, machine timer, machine external and supervisor external) are sampled into their pending bits on every clock edge, and these samples override anything software tries to write there. Software can change only the supervisor-software and supervisor-timer pending bits. The block drives one level interrupt request toward the core. The request rises in the cycle the pending word leaves zero and falls in the cycle it returns to zero. Priority selection and cause encoding are handled elsewhere.

Top module: `irq_pend_deleg`

## Requirements
- R1: After a synchronous reset, all five register views read zero and `irq_o` is low.
- R2: A write to the delegation view (select 2) stores only bits 1, 5, 9 and the coprocessor bit `COP_BIT` (default 12). Every other bit reads zero.
- R3: A write to the machine enable view (select 1) stores only bits 1, 3, 5, 7, 9 and `COP_BIT`. Every other bit reads zero.
- R4: A write to the machine pending view (select 0) changes only pending bits 1 (supervisor software) and 5 (supervisor timer). Every other pending bit is unaffected by the written value.
- R5: Pending bit 3 follows `hw_msw_i`, bit 7 follows `hw_mtmr_i`, bit 11 follows `hw_mext_i` and bit 9 follows `hw_sext_i`, one clock after sampling, whatever is written. Pending bit `COP_BIT` stays zero.
- R6: A write to the supervisor pending view (select 3) replaces only the delegated pending bits. The result then passes through the rule of R4, so only delegated bits among 1 and 5 can change.
- R7: A write to the supervisor enable view (select 4) replaces only the enable bits that are set in the delegation word.
- R8: A read of select 3 returns pending AND delegation. A read of select 4 returns enable AND delegation. Selects 0, 1 and 2 return the raw words.
- R9: `irq_o` rises on the clock edge where the pending word changes from zero to nonzero. It falls on the edge where the pending word returns to zero.
- R10: Select codes 5 to 7 read zero, and a write to any of them changes no register.
- R11: Read data is combinational in the select code, and a read with the write strobe low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we_i | input | 1 | Write strobe for the selected view |
| csr_sel_i | input | 3 | View select: 0 machine pending, 1 machine enable, 2 delegation, 3 supervisor pending, 4 supervisor enable |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected view |
| hw_msw_i | input | 1 | Machine software request line |
| hw_mtmr_i | input | 1 | Machine timer request line |
| hw_mext_i | input | 1 | Machine external request line |
| hw_sext_i | input | 1 | Supervisor external request line |
| irq_o | output | 1 | Level interrupt request toward the core |

## Verification
The bench builds the block with XLEN = 32 and COP_BIT = 12. With these values, the bits above the coprocessor bit are reachable, and random write data must be seen to leave them zero in every view. Random request lines are held low three quarters of the time, so the pending word drops back to zero often enough to exercise both edges of the interrupt request. Directed all-ones writes to each view expose the exact mask of each register. Random selects cover the unused codes 5 to 7.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int unsigned MASK_W = 64;

    // fixed bit positions inside the interrupt words
    localparam int unsigned B_SSW  = 1;
    localparam int unsigned B_MSW  = 3;
    localparam int unsigned B_STMR = 5;
    localparam int unsigned B_MTMR = 7;
    localparam int unsigned B_SEXT = 9;
    localparam int unsigned B_MEXT = 11;

    typedef enum logic [2:0] {
        SEL_MPEND = 3'd0,
        SEL_MEN   = 3'd1,
        SEL_DLG   = 3'd2,
        SEL_SPEND = 3'd3,
        SEL_SEN   = 3'd4
    } view_sel_e;

    typedef struct packed {
        logic m_sw;
        logic m_tmr;
        logic m_ext;
        logic s_ext;
    } hw_lines_t;

    typedef struct packed {
        logic wr_mpend;
        logic wr_spend;
        logic wr_men;
        logic wr_sen;
        logic wr_dlg;
    } wr_dec_t;

    function automatic logic [MASK_W-1:0] dlg_mask(input int unsigned cop);
        logic [MASK_W-1:0] m;
        m = '0;
        m[B_SSW]  = 1'b1;
        m[B_STMR] = 1'b1;
        m[B_SEXT] = 1'b1;
        m[cop]    = 1'b1;
        return m;
    endfunction

    function automatic logic [MASK_W-1:0] en_mask(input int unsigned cop);
        logic [MASK_W-1:0] m;
        m = dlg_mask(cop);
        m[B_MSW]  = 1'b1;
        m[B_MTMR] = 1'b1;
        return m;
    endfunction

    function automatic logic [MASK_W-1:0] sw_pend_mask();
        logic [MASK_W-1:0] m;
        m = '0;
        m[B_SSW]  = 1'b1;
        m[B_STMR] = 1'b1;
        return m;
    endfunction

    function automatic wr_dec_t decode_wr(input logic we, input logic [2:0] sel);
        wr_dec_t d;
        d.wr_mpend = we && (sel == SEL_MPEND);
        d.wr_spend = we && (sel == SEL_SPEND);
        d.wr_men   = we && (sel == SEL_MEN);
        d.wr_sen   = we && (sel == SEL_SEN);
        d.wr_dlg   = we && (sel == SEL_DLG);
        return d;
    endfunction

endpackage

// File: rtl/irqd_mask_reg.sv
module irqd_mask_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEEP = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wval,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~KEEP) | (wval & KEEP);
        end
    end
endmodule

// File: rtl/irqd_pend_reg.sv
module irqd_pend_reg
    import irqd_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wval,
    input  hw_lines_t    hw,
    output logic [W-1:0] pend_d,
    output logic [W-1:0] pend_q
);
    localparam logic [W-1:0] SWM = W'(sw_pend_mask());

    logic [W-1:0] hw_vec;

    always_comb begin
        hw_vec         = '0;
        hw_vec[B_MSW]  = hw.m_sw;
        hw_vec[B_MTMR] = hw.m_tmr;
        hw_vec[B_MEXT] = hw.m_ext;
        hw_vec[B_SEXT] = hw.s_ext;
        pend_d = ((we ? wval : pend_q) & SWM) | hw_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/irqd_req_gen.sv
module irqd_req_gen #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pend_cur,
    input  logic [W-1:0] pend_nxt,
    output logic         req
);
    logic cur_zero;
    logic nxt_zero;

    assign cur_zero = (pend_cur == '0);
    assign nxt_zero = (pend_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (cur_zero && !nxt_zero) begin
            req <= 1'b1;
        end else if (!cur_zero && nxt_zero) begin
            req <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pend_deleg.sv
module irq_pend_deleg
    import irqd_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned COP_BIT = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_we_i,
    input  logic [2:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic [XLEN-1:0] csr_rdata_o,
    input  logic            hw_msw_i,
    input  logic            hw_mtmr_i,
    input  logic            hw_mext_i,
    input  logic            hw_sext_i,
    output logic            irq_o
);
    localparam logic [XLEN-1:0] DLG_KEEP = XLEN'(dlg_mask(COP_BIT));
    localparam logic [XLEN-1:0] EN_KEEP  = XLEN'(en_mask(COP_BIT));

    wr_dec_t          dec;
    hw_lines_t        hw;
    logic [XLEN-1:0]  pend_q;
    logic [XLEN-1:0]  pend_d;
    logic [XLEN-1:0]  en_q;
    logic [XLEN-1:0]  dl_q;
    logic [XLEN-1:0]  pend_wval;
    logic [XLEN-1:0]  en_wval;

    assign dec = decode_wr(csr_we_i, csr_sel_i);
    assign hw  = '{m_sw: hw_msw_i, m_tmr: hw_mtmr_i, m_ext: hw_mext_i, s_ext: hw_sext_i};

    // supervisor writes are merged through the delegation window
    always_comb begin
        pend_wval = dec.wr_spend ? ((pend_q & ~dl_q) | (csr_wdata_i & dl_q)) : csr_wdata_i;
        en_wval   = dec.wr_sen   ? ((en_q & ~dl_q) | (csr_wdata_i & dl_q))   : csr_wdata_i;
    end

    irqd_mask_reg #(.W(XLEN), .KEEP(DLG_KEEP)) u_dlg (
        .clk  (clk),
        .rst  (rst),
        .we   (dec.wr_dlg),
        .wval (csr_wdata_i),
        .q    (dl_q)
    );

    irqd_mask_reg #(.W(XLEN), .KEEP(EN_KEEP)) u_en (
        .clk  (clk),
        .rst  (rst),
        .we   (dec.wr_men | dec.wr_sen),
        .wval (en_wval),
        .q    (en_q)
    );

    irqd_pend_reg #(.W(XLEN)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .we     (dec.wr_mpend | dec.wr_spend),
        .wval   (pend_wval),
        .hw     (hw),
        .pend_d (pend_d),
        .pend_q (pend_q)
    );

    irqd_req_gen #(.W(XLEN)) u_req (
        .clk      (clk),
        .rst      (rst),
        .pend_cur (pend_q),
        .pend_nxt (pend_d),
        .req      (irq_o)
    );

    always_comb begin
        unique case (csr_sel_i)
            SEL_MPEND: csr_rdata_o = pend_q;
            SEL_MEN:   csr_rdata_o = en_q;
            SEL_DLG:   csr_rdata_o = dl_q;
            SEL_SPEND: csr_rdata_o = pend_q & dl_q;
            SEL_SEN:   csr_rdata_o = en_q & dl_q;
            default:   csr_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
    import irqd_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned COP_BIT = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_we_i,
    input logic [2:0]      csr_sel_i,
    input logic [XLEN-1:0] csr_wdata_i,
    input logic            hw_msw_i,
    input logic            hw_mtmr_i,
    input logic            hw_mext_i,
    input logic            hw_sext_i,
    input logic            irq_o,
    input logic [XLEN-1:0] pend_q,
    input logic [XLEN-1:0] en_q,
    input logic [XLEN-1:0] dl_q
);
    localparam logic [XLEN-1:0] DLG_KEEP = XLEN'(dlg_mask(COP_BIT));

    logic seen_clk;
    always_ff @(posedge clk) begin
        if (rst) seen_clk <= 1'b0;
        else     seen_clk <= 1'b1;
    end

    // R2
    dlg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_sel_i == 3'd2) |=> (dl_q == ($past(csr_wdata_i) & DLG_KEEP)));

    // R10
    dlg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(csr_we_i && csr_sel_i == 3'd2) |=> $stable(dl_q));

    // R7
    sen_write_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_sel_i == 3'd4) |=>
        (en_q == (($past(en_q) & ~$past(dl_q)) | ($past(csr_wdata_i) & $past(dl_q)))));

    // R5
    hw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q[B_MSW] == $past(hw_msw_i) && pend_q[B_MTMR] == $past(hw_mtmr_i) &&
                  pend_q[B_MEXT] == $past(hw_mext_i) && pend_q[B_SEXT] == $past(hw_sext_i)));

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (rst || !seen_clk)
        irq_o == (pend_q != '0));

    // R4
    pend_cop_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q[COP_BIT] == 1'b0));
endmodule

bind irq_pend_deleg irqd_chk #(.XLEN(XLEN), .COP_BIT(COP_BIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_i),
    .csr_wdata_i (csr_wdata_i),
    .hw_msw_i    (hw_msw_i),
    .hw_mtmr_i   (hw_mtmr_i),
    .hw_mext_i   (hw_mext_i),
    .hw_sext_i   (hw_sext_i),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .dl_q        (dl_q)
);

// File: tb/sim_irq_pend_deleg.sv
`timescale 1ns/100ps
module sim_irq_pend_deleg;
    localparam logic [31:0] M_DLG = 32'h0000_1222;
    localparam logic [31:0] M_EN  = 32'h0000_12AA;
    localparam logic [31:0] M_SW  = 32'h0000_0022;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        h_msw = 0, h_mtmr = 0, h_mext = 0, h_sext = 0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [31:0] mp = '0, me = '0, md = '0;

    always #4 clk = ~clk;

    irq_pend_deleg #(.XLEN(32), .COP_BIT(12)) u0 (
        .clk(clk), .rst(rst), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
        .csr_rdata_o(rdata), .hw_msw_i(h_msw), .hw_mtmr_i(h_mtmr), .hw_mext_i(h_mext),
        .hw_sext_i(h_sext), .irq_o(irq)
    );

    function automatic logic [31:0] hw_word(input logic a, input logic b, input logic c, input logic d);
        logic [31:0] v = '0;
        v[3] = a; v[7] = b; v[11] = c; v[9] = d;
        return v;
    endfunction

    function automatic logic [31:0] view(input logic [2:0] s);
        case (s)
            3'd0: return mp;
            3'd1: return me;
            3'd2: return md;
            3'd3: return mp & md;
            3'd4: return me & md;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req);
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            #0.4;
            check(req, rdata, view(3'(s)));
        end
        check({req, " R9 irq"}, {31'b0, irq}, {31'b0, mp != 0});
    endtask

    task automatic op(input logic w, input logic [2:0] s, input logic [31:0] d,
                      input logic [3:0] hw, input string req);
        logic [31:0] np, ne, nd, wv;
        @(negedge clk);
        we = w; sel = s; wdata = d;
        {h_msw, h_mtmr, h_mext, h_sext} = hw;
        np = mp & M_SW; ne = me; nd = md;
        if (w && s == 3'd0) np = d & M_SW;
        if (w && s == 3'd3) begin
            wv = (mp & ~md) | (d & md);
            np = wv & M_SW;
        end
        np = np | hw_word(hw[3], hw[2], hw[1], hw[0]);
        if (w && s == 3'd1) ne = (me & ~M_EN) | (d & M_EN);
        if (w && s == 3'd4) ne = (me & ~md) | (d & md);
        if (w && s == 3'd2) nd = d & M_DLG;
        @(posedge clk);
        mp = np; me = ne; md = nd;
        #0.5;
        we = 1'b0;
        read_all(req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        read_all("R1 reset");

        op(1, 3'd2, 32'hFFFF_FFFF, 4'b0000, "R2 deleg mask");
        op(1, 3'd1, 32'hFFFF_FFFF, 4'b0000, "R3 enable mask");
        op(1, 3'd0, 32'hFFFF_FFFF, 4'b0000, "R4 mpend sw bits");
        check("R4 mpend value", mp, 32'h22);
        op(1, 3'd0, 32'h0, 4'b0000, "R9 irq falls");
        check("R9 irq low", {31'b0, irq}, 32'h0);
        op(1, 3'd0, 32'hFFFF_FFFF, 4'b1111, "R5 hw override");
        op(1, 3'd0, 32'h0, 4'b1010, "R5 hw override partial");
        op(1, 3'd2, 32'h0000_0020, 4'b0000, "R2 deleg stimer only");
        op(1, 3'd3, 32'hFFFF_FFFF, 4'b0000, "R6 spend delegated bit");
        check("R6 only bit5", mp, 32'h20);
        op(1, 3'd4, 32'h0, 4'b0000, "R7 senable clears delegated");
        op(1, 3'd6, 32'hFFFF_FFFF, 4'b0000, "R10 unused select");
        op(0, 3'd0, 32'hFFFF_FFFF, 4'b0000, "R11 read only");
        op(1, 3'd3, 32'h0, 4'b0000, "R8 spend view");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] hw;
            for (int k = 0; k < 4; k++) hw[k] = ($urandom % 4) == 0;
            op(1'($urandom % 2), 3'($urandom % 8), $urandom, hw, "R6 R7 R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule